// File: doc/BRIEF.md
# Incremental Bus XOR Precoder

This block maps an N-bit data word onto N+1 binary wire levels so that every data bit shows up as the difference between two neighbouring wires. A receiver then needs only adjacent-pair comparisons, which gives it common-mode rejection on N+1 lines instead of 2N. The lowest wire carries a fixed reference level. Each higher wire is the previous wire XOR the matching data bit, so wire k+1 carries the reference XORed with the parity of data bits 0..k.

The running parity is computed by a logarithmic-depth parallel-prefix XOR network and captured in an output register. A matching decoder takes the sliced wire levels and recovers each bit as the XOR of adjacent wires. It also flags a received word whose reference wire holds the wrong level. Both directions accept a new word every cycle, and each adds one cycle of latency.

Top module: `incbus_precoder`

## Requirements
- R1: After reset, every bit of `wires_o` equals `REF_LEVEL`, `data_o` is zero, and `wires_valid_o`, `data_valid_o` and `ref_err_o` are low.
- R2: Whenever `wires_valid_o` is high, `wires_o[0]` equals `REF_LEVEL` (default 0).
- R3: For an accepted word d, `wires_o[k+1] ^ wires_o[k] == d[k]` for every k in 0..N-1, which gives `wires_o[k+1] = REF_LEVEL ^ d[0] ^ ... ^ d[k]`.
- R4: `wires_valid_o` is high exactly in the cycle after a cycle with `data_valid_i` high. Back-to-back words come out in consecutive cycles with no bubble.
- R5: In a cycle with `data_valid_i` low, `wires_o` keeps its previous value whatever `data_i` holds.
- R6: One cycle after `sliced_valid_i` is high, `data_o[k] == sliced_i[k+1] ^ sliced_i[k]` for the word sampled then, and `data_valid_o` is high.
- R7: In a cycle with `sliced_valid_i` low, `data_o` keeps its previous value, and `data_valid_o` is low in the following cycle.
- R8: `ref_err_o` is high in the cycle after a valid sliced word whose bit 0 differs from `REF_LEVEL`, and low in every other cycle.
- R9: When `wires_o` is fed back to `sliced_i` as a valid word, `data_o` returns the original word and `ref_err_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | N | Data word to encode |
| data_valid_i | input | 1 | `data_i` holds a word this cycle |
| wires_o | output | N+1 | Encoded wire levels, bit 0 is the reference wire |
| wires_valid_o | output | 1 | `wires_o` was updated by the last clock edge |
| sliced_i | input | N+1 | Sliced levels of the received wires |
| sliced_valid_i | input | 1 | `sliced_i` holds a word this cycle |
| data_o | output | N | Decoded data word |
| data_valid_o | output | 1 | `data_o` was updated by the last clock edge |
| ref_err_o | output | 1 | Last valid received word had a wrong reference level |

## Verification
The assertions assume the valid strobes and the data and level inputs are settled at each rising edge. They also assume the reset is released away from a clock edge. They place no limits on data values, strobe patterns or the content of a received reference wire. The stimulus changes inputs only on falling edges and mixes random words with directed extremes (all zeros, all ones, alternating bits, a lone MSB). Strobe gaps carry random garbage on the data lines, and received words deliberately get a wrong reference bit.

// File: rtl/incbus_pkg.sv
package incbus_pkg;
  parameter int unsigned DefWidth = 32;

  function automatic int unsigned prefix_levels(int unsigned n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction
endpackage

// File: rtl/incbus_prefix_xor.sv
// Kogge-Stone inclusive prefix XOR: par_o[i] = x_i[0] ^ ... ^ x_i[i]
module incbus_prefix_xor #(
  parameter int unsigned N = incbus_pkg::DefWidth
) (
  input  logic [N-1:0] x_i,
  output logic [N-1:0] par_o
);
  localparam int unsigned Levels = incbus_pkg::prefix_levels(N);

  logic [N-1:0] stg [0:Levels];

  assign stg[0] = x_i;

  for (genvar l = 0; l < int'(Levels); l++) begin : g_lvl
    localparam int Dist = 1 << l;
    for (genvar i = 0; i < int'(N); i++) begin : g_bit
      if (i >= Dist) begin : g_comb
        assign stg[l+1][i] = stg[l][i] ^ stg[l][i-Dist];
      end else begin : g_pass
        assign stg[l+1][i] = stg[l][i];
      end
    end
  end

  assign par_o = stg[Levels];
endmodule

// File: rtl/incbus_enc.sv
module incbus_enc #(
  parameter int unsigned N         = incbus_pkg::DefWidth,
  parameter bit          REF_LEVEL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] data_i,
  input  logic         valid_i,
  output logic [N:0]   wires_o,
  output logic         valid_o
);
  localparam logic [N:0] RstWires = {(N+1){REF_LEVEL}};

  logic [N-1:0] par;
  logic [N:0]   wires_d, wires_q;
  logic         vld_q;

  incbus_prefix_xor #(.N(N)) u_pfx (
    .x_i  (data_i),
    .par_o(par)
  );

  assign wires_d = {par ^ {N{REF_LEVEL}}, REF_LEVEL};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wires_q <= RstWires;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) wires_q <= wires_d;
    end
  end

  assign wires_o = wires_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/incbus_dec.sv
module incbus_dec #(
  parameter int unsigned N         = incbus_pkg::DefWidth,
  parameter bit          REF_LEVEL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N:0]   lvl_i,
  input  logic         valid_i,
  output logic [N-1:0] data_o,
  output logic         valid_o,
  output logic         ref_err_o
);
  logic [N-1:0] data_d, data_q;
  logic         vld_q, err_q;

  // adjacent-lane difference modulo 2
  assign data_d = lvl_i[N:1] ^ lvl_i[N-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      vld_q <= valid_i;
      err_q <= valid_i && (lvl_i[0] != REF_LEVEL);
      if (valid_i) data_q <= data_d;
    end
  end

  assign data_o    = data_q;
  assign valid_o   = vld_q;
  assign ref_err_o = err_q;
endmodule

// File: rtl/incbus_precoder.sv
module incbus_precoder #(
  parameter int unsigned N         = incbus_pkg::DefWidth,
  parameter bit          REF_LEVEL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] data_i,
  input  logic         data_valid_i,
  output logic [N:0]   wires_o,
  output logic         wires_valid_o,
  input  logic [N:0]   sliced_i,
  input  logic         sliced_valid_i,
  output logic [N-1:0] data_o,
  output logic         data_valid_o,
  output logic         ref_err_o
);
  incbus_enc #(.N(N), .REF_LEVEL(REF_LEVEL)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .valid_i(data_valid_i),
    .wires_o(wires_o),
    .valid_o(wires_valid_o)
  );

  incbus_dec #(.N(N), .REF_LEVEL(REF_LEVEL)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (sliced_i),
    .valid_i  (sliced_valid_i),
    .data_o   (data_o),
    .valid_o  (data_valid_o),
    .ref_err_o(ref_err_o)
  );
endmodule

// File: rtl/incbus_precoder_chk.sv
module incbus_precoder_chk #(
  parameter int unsigned N         = 32,
  parameter bit          REF_LEVEL = 1'b0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] data_i,
  input logic         data_valid_i,
  input logic [N:0]   wires_o,
  input logic         wires_valid_o,
  input logic [N:0]   sliced_i,
  input logic         sliced_valid_i,
  input logic [N-1:0] data_o,
  input logic         data_valid_o,
  input logic         ref_err_o
);
  p_ref_wire_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wires_valid_o |-> (wires_o[0] == REF_LEVEL));

  p_encode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_i |=> ((wires_o[N:1] ^ wires_o[N-1:0]) == $past(data_i)));

  p_valid_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_i |=> wires_valid_o);

  p_no_spurious_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_i |=> !wires_valid_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_i |=> $stable(wires_o));

  p_decode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sliced_valid_i |=> (data_valid_o && (data_o == $past(sliced_i[N:1] ^ sliced_i[N-1:0]))));

  p_dec_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sliced_valid_i |=> ($stable(data_o) && !data_valid_o));

  p_ref_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sliced_valid_i && (sliced_i[0] != REF_LEVEL)) |=> ref_err_o);

  p_ref_ok_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sliced_valid_i && (sliced_i[0] != REF_LEVEL)) |=> !ref_err_o);
endmodule

bind incbus_precoder incbus_precoder_chk #(.N(N), .REF_LEVEL(REF_LEVEL)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .data_i        (data_i),
  .data_valid_i  (data_valid_i),
  .wires_o       (wires_o),
  .wires_valid_o (wires_valid_o),
  .sliced_i      (sliced_i),
  .sliced_valid_i(sliced_valid_i),
  .data_o        (data_o),
  .data_valid_o  (data_valid_o),
  .ref_err_o     (ref_err_o)
);

// File: tb/incbus_precoder_tb.sv
`timescale 1ns/1ps
module incbus_precoder_tb;
  localparam int unsigned N   = 32;
  localparam bit          REF = 1'b0;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] data_i = '0;
  logic         data_valid_i = 1'b0;
  logic [N:0]   wires_o;
  logic         wires_valid_o;
  logic [N:0]   sliced_i = '0;
  logic         sliced_valid_i = 1'b0;
  logic [N-1:0] data_o;
  logic         data_valid_o;
  logic         ref_err_o;

  int errors = 0;
  int checks = 0;
  logic [N:0]   exp_wires;
  logic [N-1:0] exp_data;

  always #2.5 clk_i = ~clk_i;

  incbus_precoder #(.N(N), .REF_LEVEL(REF)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .data_i(data_i), .data_valid_i(data_valid_i),
    .wires_o(wires_o), .wires_valid_o(wires_valid_o),
    .sliced_i(sliced_i), .sliced_valid_i(sliced_valid_i),
    .data_o(data_o), .data_valid_o(data_valid_o), .ref_err_o(ref_err_o)
  );

  function automatic logic [N:0] enc(logic [N-1:0] d);
    logic [N:0] w;
    w[0] = REF;
    for (int k = 0; k < int'(N); k++) w[k+1] = w[k] ^ d[k];
    return w;
  endfunction

  function automatic logic [N-1:0] dec(logic [N:0] s);
    logic [N-1:0] d;
    for (int k = 0; k < int'(N); k++) d[k] = s[k+1] ^ s[k];
    return d;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic send(logic [N-1:0] d);
    data_i = d;
    data_valid_i = 1'b1;
    @(negedge clk_i);
    exp_wires = enc(d);
    chk(wires_o == exp_wires, "R3", 64'(wires_o), 64'(exp_wires));
    chk(wires_o[0] == REF, "R2", 64'(wires_o[0]), 64'(REF));
    chk(wires_valid_o == 1'b1, "R4", 64'(wires_valid_o), 64'd1);
  endtask

  task automatic enc_idle();
    data_valid_i = 1'b0;
    data_i = {$urandom, $urandom};
    @(negedge clk_i);
    chk(wires_o == exp_wires, "R5", 64'(wires_o), 64'(exp_wires));
    chk(wires_valid_o == 1'b0, "R4", 64'(wires_valid_o), 64'd0);
  endtask

  task automatic recv(logic [N:0] s);
    sliced_i = s;
    sliced_valid_i = 1'b1;
    @(negedge clk_i);
    exp_data = dec(s);
    chk(data_o == exp_data, "R6", 64'(data_o), 64'(exp_data));
    chk(data_valid_o == 1'b1, "R6", 64'(data_valid_o), 64'd1);
    chk(ref_err_o == (s[0] != REF), "R8", 64'(ref_err_o), 64'(s[0] != REF));
  endtask

  task automatic dec_idle(bit bad_ref);
    sliced_valid_i = 1'b0;
    sliced_i = {$urandom, $urandom};
    sliced_i[0] = bad_ref ? ~REF : REF;
    @(negedge clk_i);
    chk(data_o == exp_data, "R7", 64'(data_o), 64'(exp_data));
    chk(data_valid_o == 1'b0, "R7", 64'(data_valid_o), 64'd0);
    chk(ref_err_o == 1'b0, "R8", 64'(ref_err_o), 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    logic [N-1:0] d;
    void'($urandom(32'hC0DE_1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(wires_o == {(N+1){REF}}, "R1", 64'(wires_o), 64'({(N+1){REF}}));
    chk(data_o == '0, "R1", 64'(data_o), 64'd0);
    chk({wires_valid_o, data_valid_o, ref_err_o} == 3'b000, "R1",
        64'({wires_valid_o, data_valid_o, ref_err_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    exp_wires = {(N+1){REF}};
    exp_data = '0;

    // directed corner words, back to back (R4 no bubble)
    send('0);
    send('1);
    send({(N/2){2'b10}});
    send({(N/2){2'b01}});
    send({1'b1, {(N-1){1'b0}}});
    send({{(N-1){1'b0}}, 1'b1});
    enc_idle();
    enc_idle();

    // random words with random gaps
    for (int i = 0; i < 200; i++) begin
      d = {$urandom, $urandom};
      send(d);
      if ($urandom_range(0, 2) == 0) enc_idle();
    end
    enc_idle();

    // decoder: directed and random, some with wrong reference (R8)
    recv('0);
    recv('1);
    recv({(N+1){1'b0}} | 1);
    dec_idle(1'b1);
    for (int i = 0; i < 200; i++) begin
      recv({$urandom, $urandom, 1'($urandom)});
      if ($urandom_range(0, 2) == 0) dec_idle(1'($urandom));
    end
    dec_idle(1'b0);

    // R9 loopback through wires
    for (int i = 0; i < 50; i++) begin
      d = {$urandom, $urandom};
      send(d);
      data_valid_i = 1'b0;
      sliced_i = wires_o;
      sliced_valid_i = 1'b1;
      @(negedge clk_i);
      chk(data_o == d, "R9", 64'(data_o), 64'(d));
      chk(ref_err_o == 1'b0, "R9", 64'(ref_err_o), 64'd0);
      sliced_valid_i = 1'b0;
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule